// File: doc/BRIEF.md
# Carry-Select Sequential PC Advancer

This block produces the address of the next sequential instruction for an instruction set whose encodings are one to six bytes long. The byte count follows from two decode flags: one says the encoding carries a register-specifier byte, the other says it carries a four-byte constant word.

The computation is split so that the slow part starts early. The program counter is cut into a wide upper field and a 3-bit lower field. An incrementer forms the upper field plus one as soon as the program counter is known, while the instruction memory is still being read. Once decode has produced the two flags, a narrow 3-bit adder adds the length to the lower field. Its carry-out then picks either the plain or the incremented upper field. Only the narrow adder and one multiplexer sit after the flags arrive.

The block is purely combinational. Instruction memory and decode sit outside it.

Top module: `seq_pc_adv`

## Requirements
- R1: `next_pc_o` equals `pc_i` plus the instruction length, modulo 2^32, for every input combination.
- R2: The length is 1, plus 1 when `has_reg_byte_i` is high, plus 4 when `has_const_word_i` is high. The four flag pairs (reg, const) = (0,0), (1,0), (0,1), (1,1) therefore give lengths 1, 2, 5 and 6.
- R3: Bits [2:0] of `next_pc_o` equal (`pc_i[2:0]` + length) modulo 8.
- R4: When `pc_i[2:0]` + length is below 8, bits [31:3] of `next_pc_o` equal bits [31:3] of `pc_i`.
- R5: When `pc_i[2:0]` + length is 8 or more, bits [31:3] of `next_pc_o` equal bits [31:3] of `pc_i` plus one, modulo 2^29.
- R6: At the top of the address space the result wraps. When bits [31:3] of `pc_i` are all ones and the lower sum carries, `next_pc_o` is numerically smaller than `pc_i`.
- R7: `next_pc_o` minus `pc_i`, modulo 2^32, always lies between 1 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| has_reg_byte_i | input | 1 | Encoding carries a register-specifier byte |
| has_const_word_i | input | 1 | Encoding carries a four-byte constant word |
| next_pc_o | output | 32 | Address of the next sequential instruction |

## Verification
The immediate assertions assume the inputs are two-state: no X or Z on the program counter or the flags. The bench keeps to this by setting every input at declaration and only ever driving defined values. The stimulus sweeps every lower-field value against every flag pair. Each sweep is repeated over a set of upper-field values that includes zero, all ones (the wrap case), alternating bit patterns and a long pseudo-random sequence. Expected results are formed arithmetically with a full-width addition.

// File: rtl/seq_pc_adv_pkg.sv
// Package: shared widths and the decode-flag bundle for the sequential PC advancer.
// Assumes the lower field is wide enough to hold the largest length (6).
package seq_pc_adv_pkg;
    parameter int PC_W  = 32;
    parameter int LOW_W = 3;

    // Decode flags that set the instruction length
    typedef struct packed {
        logic reg_byte;
        logic const_word;
    } len_flags_t;
endpackage

// File: rtl/spa_len_decode.sv
// Module: turns the two decode flags into a byte count of 1, 2, 5 or 6.
// Assumes LEN_W >= 3 so the largest count fits.
module spa_len_decode
    import seq_pc_adv_pkg::*;
#(
    parameter int LEN_W = LOW_W
) (
    input  len_flags_t       flags_i,
    output logic [LEN_W-1:0] len_o
);
    localparam logic [LEN_W-1:0] BASE_LEN  = LEN_W'(1);
    localparam logic [LEN_W-1:0] REG_LEN   = LEN_W'(1);
    localparam logic [LEN_W-1:0] CONST_LEN = LEN_W'(4);

    // Sum the base byte and the optional field sizes
    always_comb begin
        len_o = BASE_LEN
              + (flags_i.reg_byte   ? REG_LEN   : '0)
              + (flags_i.const_word ? CONST_LEN : '0);
    end

    // R2: the length stays within 1..6 for every flag pair
    always_comb begin
        p_len_range_r2: assert (len_o >= LEN_W'(1) && len_o <= LEN_W'(6))
            else $error("length out of range");
    end
endmodule

// File: rtl/spa_high_incr.sv
// Module: early incrementer for the upper PC field. It depends only on the PC,
// so it can settle while the instruction memory is being read.
// Assumes wraparound modulo 2^HIGH_W is wanted.
module spa_high_incr #(
    parameter int HIGH_W = 29
) (
    input  logic [HIGH_W-1:0] hi_i,
    output logic [HIGH_W-1:0] hi_inc_o
);
    // Add one to the upper field
    always_comb begin
        hi_inc_o = hi_i + HIGH_W'(1);
    end
endmodule

// File: rtl/spa_low_add.sv
// Module: narrow adder for the lower PC field and the length; also gives the carry out.
// Assumes the length fits in LOW_W bits.
module spa_low_add #(
    parameter int LOW_W = 3
) (
    input  logic [LOW_W-1:0] lo_i,
    input  logic [LOW_W-1:0] len_i,
    output logic [LOW_W-1:0] sum_o,
    output logic             carry_o
);
    // Add with one extra bit to catch the carry
    always_comb begin
        {carry_o, sum_o} = {1'b0, lo_i} + {1'b0, len_i};
    end
endmodule

// File: rtl/seq_pc_adv.sv
// Module: next sequential PC through a carry-select split. The upper field is
// incremented early, and the carry of the narrow lower add picks the upper result.
// Assumes two-state inputs and no storage: the block is purely combinational.
module seq_pc_adv
    import seq_pc_adv_pkg::*;
#(
    parameter int ADDR_W = PC_W,
    parameter int SPLIT  = LOW_W
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              has_reg_byte_i,
    input  logic              has_const_word_i,
    output logic [ADDR_W-1:0] next_pc_o
);
    localparam int HIGH_W = ADDR_W - SPLIT;

    len_flags_t        flags;
    logic [SPLIT-1:0]  len;
    logic [SPLIT-1:0]  lo_sum;
    logic              lo_carry;
    logic [HIGH_W-1:0] hi_inc;
    logic [HIGH_W-1:0] hi_sel;

    // Bundle the decode flags
    always_comb begin
        flags.reg_byte   = has_reg_byte_i;
        flags.const_word = has_const_word_i;
    end

    spa_len_decode #(.LEN_W(SPLIT)) u_len (
        .flags_i (flags),
        .len_o   (len)
    );

    spa_high_incr #(.HIGH_W(HIGH_W)) u_hinc (
        .hi_i     (pc_i[ADDR_W-1:SPLIT]),
        .hi_inc_o (hi_inc)
    );

    spa_low_add #(.LOW_W(SPLIT)) u_ladd (
        .lo_i    (pc_i[SPLIT-1:0]),
        .len_i   (len),
        .sum_o   (lo_sum),
        .carry_o (lo_carry)
    );

    // Carry picks the plain or the pre-incremented upper field
    always_comb begin
        hi_sel    = lo_carry ? hi_inc : pc_i[ADDR_W-1:SPLIT];
        next_pc_o = {hi_sel, lo_sum};
    end

    // R1 / R4 / R5 / R7: compare the split result with a single full-width add
    always_comb begin
        p_full_add_r1: assert (next_pc_o == pc_i + ADDR_W'(len))
            else $error("split result differs from full add");
        p_hold_high_r4: assert (lo_carry || next_pc_o[ADDR_W-1:SPLIT] == pc_i[ADDR_W-1:SPLIT])
            else $error("upper field moved without carry");
        p_bump_high_r5: assert (!lo_carry || next_pc_o[ADDR_W-1:SPLIT] == pc_i[ADDR_W-1:SPLIT] + HIGH_W'(1))
            else $error("upper field not bumped on carry");
        p_step_range_r7: assert ((next_pc_o - pc_i) >= ADDR_W'(1) && (next_pc_o - pc_i) <= ADDR_W'(6))
            else $error("step out of range");
    end
endmodule

// File: tb/tb_seq_pc_adv.sv
// Bench: sweeps every lower-field value and flag pair over many upper-field values.
module tb_seq_pc_adv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0;
    logic        rb = 1'b0;
    logic        cw = 1'b0;
    logic [31:0] npc;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    seq_pc_adv dut (
        .pc_i             (pc),
        .has_reg_byte_i   (rb),
        .has_const_word_i (cw),
        .next_pc_o        (npc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pc=%h rb=%0b cw=%0b actual=%h expected=%h", req, pc, rb, cw, act, exp);
        end
    endtask

    task automatic apply(input logic [28:0] hi, input logic [2:0] lo, input logic r, input logic c);
        logic [31:0] len_e;
        logic [31:0] exp;
        logic [3:0]  lsum;
        @(posedge clk);
        pc = {hi, lo};
        rb = r;
        cw = c;
        @(negedge clk);
        len_e = 32'd1 + (r ? 32'd1 : 32'd0) + (c ? 32'd4 : 32'd0);
        exp   = pc + len_e;
        lsum  = {1'b0, lo} + len_e[3:0];
        check("R1", npc, exp);
        check("R2", npc - pc, len_e);
        check("R3", {29'd0, npc[2:0]}, {29'd0, lsum[2:0]});
        if (lsum < 4'd8) check("R4", {3'd0, npc[31:3]}, {3'd0, hi});
        else             check("R5", {3'd0, npc[31:3]}, {3'd0, hi + 29'd1});
        if (hi == '1 && lsum >= 4'd8) check("R6", {31'd0, npc < pc}, 32'd1);
        check("R7", {31'd0, (npc - pc) >= 32'd1 && (npc - pc) <= 32'd6}, 32'd1);
    endtask

    task automatic sweep(input logic [28:0] hi);
        for (int lo = 0; lo < 8; lo++)
            for (int f = 0; f < 4; f++)
                apply(hi, lo[2:0], f[0], f[1]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [28:0] lfsr;
        lfsr = 29'h1ACE_F00D;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", npc, 32'd1);   // value while the bench holds reset, inputs at zero
        rst_n = 1'b1;
        sweep(29'h0);
        sweep(29'h1);
        sweep('1);                 // R6 wrap case
        sweep(29'h1FFF_FFFE);
        sweep(29'h0AAA_AAAA);
        sweep(29'h1555_5555);
        sweep(29'h1000_0000);
        sweep(29'h0FFF_FFFF);
        for (int i = 0; i < 250; i++) begin
            lfsr = {lfsr[27:0], lfsr[28] ^ lfsr[26]};
            sweep(lfsr);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule